// File: doc/BRIEF.md
# Per-Symbol Min/Max Sample Tracker

This block takes one signed sample per clock and finds the largest and smallest value seen within each symbol period. A single-cycle strobe marks where one symbol ends and the next begins. When the strobe takes effect, the extremes of the finished symbol are copied into two result registers. On that same edge both running trackers restart from the sample that arrived with the strobe, so that sample opens the new symbol and never counts toward the old one.

The sample and the strobe pass through one input register before they reach the compare logic. A small control state machine sequences the work. Its states are ST_WARM, ST_COLLECT and ST_EMIT:
- ST_WARM is the first cycle after reset. The input register does not yet hold a real sample, so the trackers keep their values.
- ST_COLLECT is normal accumulation.
- ST_EMIT is the cycle in which fresh results are visible and the valid output is high.

The transitions are:
- warm-to-collect: always, on the edge that leaves reset.
- collect-to-emit and emit-to-emit: when the registered strobe is high.
- collect-to-collect and emit-to-collect: when the registered strobe is low.

Top module: `minmax_symbol_tracker`

## Requirements
- R1: While reset is held, both results read zero and the valid output is low.
- R2: A sample presented at an edge is folded into the trackers one edge later. A strobe presented at edge n makes new results and valid visible after edge n+1.
- R3: Between strobes, the max tracker keeps the larger of its value and the registered sample, using signed two's-complement comparison.
- R4: Between strobes, the min tracker keeps the smaller of its value and the registered sample, using signed comparison.
- R5: On a strobe, the results take the trackers' values from before the edge. The sample that arrives with the strobe is excluded from the finished symbol and becomes the first sample of the next one.
- R6: The valid output is high for exactly one cycle per strobe, in the cycle the new results first appear.
- R7: On two back-to-back strobes, the second result pair is the sample that arrived with the first strobe, for both max and min.
- R8: A strobe arriving with the very first sample after reset reports the empty-symbol values: max equals the most negative code (-128 for 8 bits) and min equals the most positive code (127).
- R9: The results hold steady in every cycle that is not a strobe result cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | W | Signed sample, one per clock |
| sym_strobe | input | 1 | One-cycle symbol boundary marker |
| max_out | output | W | Largest sample of the last finished symbol |
| min_out | output | W | Smallest sample of the last finished symbol |
| result_valid | output | 1 | One-cycle pulse when new results appear |

## Verification
The assertions assume that the strobe and sample inputs are driven synchronously, and that nothing is expected of the trackers in the warm-up cycle. The stimulus therefore changes inputs only at the falling edge, and always releases reset at a falling edge. Signed extremes, including the most negative and most positive codes, are fed through the table. Back-to-back strobes and a strobe on the first post-reset sample are exercised by the directed tests, which are where the sentinel values become visible.

// File: rtl/minmax_pkg.sv
package minmax_pkg;
    typedef enum logic [1:0] {
        ST_WARM    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_EMIT    = 2'd2
    } mm_state_e;

    typedef enum logic [1:0] {
        TK_HOLD = 2'd0,
        TK_FOLD = 2'd1,
        TK_LOAD = 2'd2
    } mm_cmd_e;
endpackage

// File: rtl/mm_input_stage.sv
module mm_input_stage #(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] sample_in,
    input  logic                strobe_in,
    output logic signed [W-1:0] sample_q,
    output logic                strobe_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= '0;
            strobe_q <= 1'b0;
        end else begin
            sample_q <= sample_in;
            strobe_q <= strobe_in;
        end
    end
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
    import minmax_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe_q,
    output mm_state_e state_q,
    output mm_cmd_e   tk_cmd,
    output logic      publish,
    output logic      valid
);
    mm_state_e state_d;

    // State register process
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WARM;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WARM:    state_d = ST_COLLECT;
            ST_COLLECT: state_d = strobe_q ? ST_EMIT : ST_COLLECT;
            ST_EMIT:    state_d = strobe_q ? ST_EMIT : ST_COLLECT;
            default:    state_d = ST_WARM;
        endcase
    end

    // Output process
    always_comb begin
        tk_cmd  = TK_HOLD;
        publish = 1'b0;
        valid   = 1'b0;
        unique case (state_q)
            ST_WARM: begin
                tk_cmd  = TK_HOLD;
                publish = 1'b0;
            end
            ST_COLLECT: begin
                tk_cmd  = strobe_q ? TK_LOAD : TK_FOLD;
                publish = strobe_q;
            end
            ST_EMIT: begin
                tk_cmd  = strobe_q ? TK_LOAD : TK_FOLD;
                publish = strobe_q;
                valid   = 1'b1;
            end
            default: begin
                tk_cmd  = TK_HOLD;
                publish = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mm_tracker.sv
module mm_tracker
    import minmax_pkg::*;
#(
    parameter int W      = 8,
    parameter bit IS_MAX = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  mm_cmd_e             cmd,
    input  logic signed [W-1:0] sample,
    output logic signed [W-1:0] cur
);
    localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] SENTINEL = IS_MAX ? MOST_NEG : MOST_POS;

    logic better;

    generate
        if (IS_MAX) begin : g_max
            assign better = (sample > cur);
        end else begin : g_min
            assign better = (sample < cur);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= SENTINEL;
        end else begin
            unique case (cmd)
                TK_LOAD: cur <= sample;
                TK_FOLD: cur <= better ? sample : cur;
                default: cur <= cur;
            endcase
        end
    end
endmodule

// File: rtl/mm_result.sv
module mm_result #(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                publish,
    input  logic signed [W-1:0] max_trk,
    input  logic signed [W-1:0] min_trk,
    output logic signed [W-1:0] max_res,
    output logic signed [W-1:0] min_res
);
    always_ff @(posedge clk) begin
        if (rst) begin
            max_res <= '0;
            min_res <= '0;
        end else if (publish) begin
            max_res <= max_trk;
            min_res <= min_trk;
        end
    end
endmodule

// File: rtl/minmax_symbol_tracker.sv
module minmax_symbol_tracker
    import minmax_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] sample_in,
    input  logic                sym_strobe,
    output logic signed [W-1:0] max_out,
    output logic signed [W-1:0] min_out,
    output logic                result_valid
);
    logic signed [W-1:0] sample_q;
    logic                strobe_q;
    logic signed [W-1:0] max_trk;
    logic signed [W-1:0] min_trk;
    mm_state_e           state_q;
    mm_cmd_e             tk_cmd;
    logic                publish;

    mm_input_stage #(.W(W)) u_in (
        .clk(clk), .rst(rst),
        .sample_in(sample_in), .strobe_in(sym_strobe),
        .sample_q(sample_q), .strobe_q(strobe_q)
    );

    mm_ctrl u_ctrl (
        .clk(clk), .rst(rst), .strobe_q(strobe_q),
        .state_q(state_q), .tk_cmd(tk_cmd),
        .publish(publish), .valid(result_valid)
    );

    mm_tracker #(.W(W), .IS_MAX(1'b1)) u_max (
        .clk(clk), .rst(rst), .cmd(tk_cmd), .sample(sample_q), .cur(max_trk)
    );

    mm_tracker #(.W(W), .IS_MAX(1'b0)) u_min (
        .clk(clk), .rst(rst), .cmd(tk_cmd), .sample(sample_q), .cur(min_trk)
    );

    mm_result #(.W(W)) u_res (
        .clk(clk), .rst(rst), .publish(publish),
        .max_trk(max_trk), .min_trk(min_trk),
        .max_res(max_out), .min_res(min_out)
    );
endmodule

// File: rtl/minmax_symbol_tracker_chk.sv
module minmax_symbol_tracker_chk
    import minmax_pkg::*;
#(
    parameter int W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                strobe_q,
    input logic signed [W-1:0] sample_q,
    input logic signed [W-1:0] max_trk,
    input logic signed [W-1:0] min_trk,
    input mm_cmd_e             tk_cmd,
    input logic signed [W-1:0] max_out,
    input logic signed [W-1:0] min_out,
    input logic                result_valid
);
    // R3: folding never lowers the max and covers the folded sample
    a_r3_max_monotone: assert property (@(posedge clk) disable iff (rst)
        (tk_cmd == TK_FOLD) |=> (max_trk >= $past(max_trk)) && (max_trk >= $past(sample_q)));

    // R4: folding never raises the min and covers the folded sample
    a_r4_min_monotone: assert property (@(posedge clk) disable iff (rst)
        (tk_cmd == TK_FOLD) |=> (min_trk <= $past(min_trk)) && (min_trk <= $past(sample_q)));

    // R5: results capture pre-edge tracker values; trackers restart from the sample
    a_r5_capture: assert property (@(posedge clk) disable iff (rst)
        (tk_cmd == TK_LOAD) |=> (max_out == $past(max_trk)) && (min_out == $past(min_trk))
                                && (max_trk == $past(sample_q)) && (min_trk == $past(sample_q)));

    // R6: valid follows the registered strobe by one cycle
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        strobe_q |=> result_valid);

    a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !strobe_q |=> !result_valid);

    // R9: results hold when no strobe is taken
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !strobe_q |=> $stable(max_out) && $stable(min_out));
endmodule

bind minmax_symbol_tracker minmax_symbol_tracker_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .strobe_q(strobe_q), .sample_q(sample_q),
    .max_trk(max_trk), .min_trk(min_trk), .tk_cmd(tk_cmd),
    .max_out(max_out), .min_out(min_out), .result_valid(result_valid)
);

// File: tb/minmax_symbol_tracker_tb.sv
module minmax_symbol_tracker_tb;
    localparam int W      = 8;
    localparam int PERIOD = 10;
    localparam int NROWS  = 13;

    // Stimulus row i is driven before edge i; expected values are observed after edge i.
    localparam int STIM_X [NROWS] = '{5, -3, 7, 2, -10, 4, 127, -128, 0, 1, 1, 0, 0};
    localparam bit STIM_S [NROWS] = '{0, 0, 0, 1, 0, 0, 1, 1, 0, 0, 1, 0, 0};
    localparam bit EXP_V  [NROWS] = '{0, 0, 0, 0, 1, 0, 0, 1, 1, 0, 0, 1, 0};
    localparam int EXP_MX [NROWS] = '{0, 0, 0, 0, 7, 7, 7, 4, 127, 127, 127, 1, 1};
    localparam int EXP_MN [NROWS] = '{0, 0, 0, 0, -3, -3, -3, -10, 127, 127, 127, -128, -128};

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic signed [W-1:0] sample_in = '0;
    logic                sym_strobe = 1'b0;
    logic signed [W-1:0] max_out;
    logic signed [W-1:0] min_out;
    logic                result_valid;

    int n_checks = 0;
    int n_fail   = 0;

    always #(PERIOD/2) clk = ~clk;

    minmax_symbol_tracker #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .sample_in(sample_in), .sym_strobe(sym_strobe),
        .max_out(max_out), .min_out(min_out), .result_valid(result_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input int x, input bit s);
        sample_in  = W'(x);
        sym_strobe = s;
    endtask

    initial begin
        #(PERIOD * 20000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid in reset", int'(result_valid), 0);
        chk("R1 max in reset", int'(max_out), 0);
        chk("R1 min in reset", int'(min_out), 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R9
        rst = 1'b0;
        for (int i = 0; i < NROWS; i++) begin
            drive(STIM_X[i], STIM_S[i]);
            @(negedge clk);
            chk($sformatf("R6 valid row %0d", i), int'(result_valid), int'(EXP_V[i]));
            chk($sformatf("R3 R5 R7 max row %0d", i), int'(max_out), EXP_MX[i]);
            chk($sformatf("R4 R5 R7 min row %0d", i), int'(min_out), EXP_MN[i]);
        end

        // R1: reset in mid-run clears results
        drive(0, 0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 valid after reset", int'(result_valid), 0);
        chk("R1 max after reset", int'(max_out), 0);
        chk("R1 min after reset", int'(min_out), 0);

        // R8: strobe with first sample after reset reports sentinels
        rst = 1'b0;
        drive(9, 1);
        @(negedge clk);
        drive(3, 0);
        @(negedge clk);
        chk("R8 valid empty symbol", int'(result_valid), 1);
        chk("R8 max sentinel", int'(max_out), -128);
        chk("R8 min sentinel", int'(min_out), 127);

        drive(-1, 1);
        @(negedge clk);
        chk("R6 single pulse", int'(result_valid), 0);
        chk("R9 max holds", int'(max_out), -128);
        drive(0, 0);
        @(negedge clk);
        // R5: symbol {9,3}; boundary sample -1 excluded
        chk("R5 valid", int'(result_valid), 1);
        chk("R5 max excludes boundary", int'(max_out), 9);
        chk("R5 min excludes boundary", int'(min_out), 3);
        @(negedge clk);
        chk("R6 pulse ends", int'(result_valid), 0);
        chk("R9 min holds", int'(min_out), 3);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule